// File: doc/BRIEF.md
# Microcode Sequencer and Instruction Decoder

This block is the control front end of a small communications microengine. It keeps the address of the next microinstruction and the 16-bit microinstruction now being executed. It paces each instruction through four fixed phases. The three opcode bits pick one of eight instruction classes. For each class the block raises the matching enable in the phase where the rest of the engine acts on it, and drives the field selects that go with it.

Branches come in two opcodes that behave the same way. Each one tests one of sixteen external condition inputs. When the selected condition is true, the block jumps to a 9-bit target built from the top instruction bit and the low byte. Otherwise the address steps by one and wraps at the end of the 512-word space.

The ROM, the arithmetic unit, the scratch RAM, the transfer-bus registers and the bus master all sit outside this block. The block drives their strobes, addresses and selects, and it reads the microword through a combinational ROM port.

Top module: `ucode_sequencer`

## Requirements
- R1: Phases repeat in the order T1 (phase_o=0), T2 (1), DS (2), FETCH (3), advancing one per clock. A synchronous active-low reset forces phase FETCH and rom_addr 0, with every strobe and op_class low.
- R2: The opcode is instruction bits 14..12, with this mapping: 000 branch-A, 001 ALU, 010 RAM, 011 transfer, 100 bus request, 101 set/clear, 110 block check, 111 branch-B. op_class bit n is high during T1, T2 and DS exactly when the opcode equals n. op_class is all zero during FETCH.
- R3: For opcodes 000 and 111, bits 11..8 pick one bit of test_pts, and that bit is sampled at the end of T1. If it is true, br_taken is high during T2, and rom_addr becomes {bit15, bits7..0} at the end of T2. A change to test_pts after T1 does not alter the decision.
- R4: For every instruction that does not take a branch, rom_addr increments by one at the end of T2, modulo 512. rom_addr changes at no other time.
- R5: At the end of FETCH the word at rom_data (addressed by rom_addr) is latched, and it is the next instruction executed.
- R6: For opcode 001, alu_strobe is high during T2 and alu_func carries bits 5..0.
- R7: For opcode 010, ram_addr is {bits3..0, line_num}. If bit 8 is 1, ram_wr pulses in DS, src_en is 1 and src_sel carries bits 7..4. If bit 8 is 0, ram_rd pulses in T2, src_en is 0 and src_sel is 0 whatever bits 7..4 hold.
- R8: For opcode 011, xfer_strobe is high during T2, src_sel carries bits 7..4 with src_en 1, and xfer_dst carries bits 2..0.
- R9: xfer_bus_wr is high during a transfer's T2 only when xfer_dst is 5 (the bus-request address register) and bit 9 is 1. Bit 9 has no effect for any other destination.
- R10: For opcode 100, busreq_strobe is high during T2.
- R11: For opcode 101, sc_strobe is high during DS and sc_func carries bits 7..0.
- R12: For opcode 110, bcc_strobe is high during DS and bcc_sel equals the ram_bits input. Instruction bits 4..3 do not affect bcc_sel.
- R13: At most one of br_taken, alu_strobe, ram_rd, ram_wr, xfer_strobe, busreq_strobe, sc_strobe, bcc_strobe is high in any cycle. Only the strobe of the executing class ever rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rom_addr | output | 9 | Address of the next microword to fetch |
| rom_data | input | 16 | Microword read combinationally at rom_addr |
| test_pts | input | 16 | Branch condition inputs |
| line_num | input | 4 | Line number forming the low RAM address nibble |
| ram_bits | input | 2 | Bits 4..3 of the RAM output register |
| phase_o | output | 2 | Current phase: 0 T1, 1 T2, 2 DS, 3 FETCH |
| op_class | output | 8 | One-hot class of the executing instruction |
| br_taken | output | 1 | Branch taken, high in T2 |
| alu_strobe | output | 1 | ALU result load enable |
| alu_func | output | 6 | ALU function select |
| ram_rd | output | 1 | RAM read strobe |
| ram_wr | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM address |
| src_en | output | 1 | Transfer-bus source select valid |
| src_sel | output | 4 | Transfer-bus source select |
| xfer_strobe | output | 1 | Transfer destination load enable |
| xfer_dst | output | 3 | Transfer destination select |
| xfer_bus_wr | output | 1 | Bus cycle direction is write for the bus address load |
| busreq_strobe | output | 1 | Bus request set pulse |
| sc_strobe | output | 1 | Set/clear function strobe |
| sc_func | output | 8 | Set/clear function code |
| bcc_strobe | output | 1 | Block-check result load enable |
| bcc_sel | output | 2 | Block-check resultant select |

## Verification
A bad phase counter shows up within one clock as a strobe in the wrong phase or a skipped phase on phase_o. A corrupted address register or a wrong branch decision shows up one clock after T2 as a wrong value on rom_addr. It is seen again two clocks later as the wrong class on op_class, because a different microword is fetched. A latched word with a wrong field shows up at T1 or T2 of that same instruction on the select outputs. That is why the tests sample each phase of several consecutive instructions, including a jump to the last address and the wrap back to zero.

// File: rtl/useq_pkg.sv
// Shared constants and types for the microcode sequencer.
// Assumes the fixed 16-bit microword format: the opcode in bits 14..12,
// and class-specific fields below it.
package useq_pkg;
    localparam int IW      = 16;             // microword width
    localparam int AW      = 9;              // ROM address width
    localparam int OPC_W   = 3;              // opcode width
    localparam int OPC_LSB = 12;             // opcode position
    localparam int NCLASS  = 1 << OPC_W;     // instruction classes
    localparam int TP_N    = 16;             // branch condition inputs
    localparam int TP_W    = $clog2(TP_N);
    localparam int LINE_W  = 4;              // line number width
    localparam int LOC_W   = 4;              // RAM location nibble width
    localparam int RAM_AW  = LOC_W + LINE_W;
    localparam int SRC_W   = 4;
    localparam int DST_W   = 3;
    localparam int ALU_W   = 6;
    localparam int SCF_W   = 8;
    localparam int BCC_W   = 2;
    localparam int PH_W    = 2;
    localparam int BR_LO_W = AW - 1;         // low byte of a branch target

    localparam logic [DST_W-1:0] DST_BUSADDR = 3'd5;

    typedef enum logic [PH_W-1:0] {
        PH_T1    = 2'd0,
        PH_T2    = 2'd1,
        PH_DS    = 2'd2,
        PH_FETCH = 2'd3
    } phase_t;

    typedef enum logic [OPC_W-1:0] {
        OP_BRA = 3'd0,
        OP_ALU = 3'd1,
        OP_RAM = 3'd2,
        OP_XFR = 3'd3,
        OP_REQ = 3'd4,
        OP_SC  = 3'd5,
        OP_BCC = 3'd6,
        OP_BRB = 3'd7
    } opcode_t;
endpackage

// File: rtl/useq_phase.sv
// Phase generator: steps T1 -> T2 -> DS -> FETCH once per clock.
// Assumes a synchronous active-low reset. Reset parks the counter in
// FETCH, so the first edge after reset loads the word at address 0.
module useq_phase
    import useq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_t phase
);
    phase_t phase_q;

    // Advance the phase, or park it in FETCH during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else begin
            phase_q <= phase_t'(PH_W'(phase_q + 2'd1));
        end
    end

    assign phase = phase_q;
endmodule

// File: rtl/useq_fetch.sv
// Fetch unit: holds the ROM address register, the instruction register
// and the captured branch decision. The decision is taken at the end of
// T1, the address is updated at the end of T2, and the next word is
// latched at the end of FETCH. Assumes rom_data follows rom_addr
// combinationally.
module useq_fetch
    import useq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  phase_t          phase,
    input  logic [IW-1:0]   rom_data,
    input  logic [TP_N-1:0] test_pts,
    input  logic            is_branch,
    input  logic [TP_W-1:0] tp_sel,
    output logic [AW-1:0]   rom_addr,
    output logic [IW-1:0]   ir,
    output logic            br_taken
);
    logic [AW-1:0] addr_q;
    logic [IW-1:0] ir_q;
    logic          br_q;
    logic [AW-1:0] target;
    logic [AW-1:0] addr_inc;
    logic          tp_val;

    assign target   = {ir_q[IW-1], ir_q[BR_LO_W-1:0]};
    assign addr_inc = addr_q + {{(AW-1){1'b0}}, 1'b1};
    assign tp_val   = test_pts[tp_sel];

    // Capture the branch condition at the end of T1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            br_q <= 1'b0;
        end else if (phase == PH_T1) begin
            br_q <= is_branch & tp_val;
        end
    end

    // Load the branch target or step the address at the end of T2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (phase == PH_T2) begin
            addr_q <= br_q ? target : addr_inc;
        end
    end

    // Latch the next microword at the end of FETCH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (phase == PH_FETCH) begin
            ir_q <= rom_data;
        end
    end

    assign rom_addr = addr_q;
    assign ir       = ir_q;
    assign br_taken = br_q & (phase == PH_T2);
endmodule

// File: rtl/useq_decode.sv
// Instruction decoder: turns the latched microword and the current phase
// into one-hot class flags, phase-timed strobes and field selects.
// A field select is zero unless its class is executing. Assumes ir is
// stable from T1 through DS.
module useq_decode
    import useq_pkg::*;
(
    input  phase_t              phase,
    input  logic [IW-1:0]       ir,
    input  logic [LINE_W-1:0]   line_num,
    input  logic [BCC_W-1:0]    ram_bits,
    output logic                is_branch,
    output logic [TP_W-1:0]     tp_sel,
    output logic [NCLASS-1:0]   op_class,
    output logic                alu_strobe,
    output logic [ALU_W-1:0]    alu_func,
    output logic                ram_rd,
    output logic                ram_wr,
    output logic [RAM_AW-1:0]   ram_addr,
    output logic                src_en,
    output logic [SRC_W-1:0]    src_sel,
    output logic                xfer_strobe,
    output logic [DST_W-1:0]    xfer_dst,
    output logic                xfer_bus_wr,
    output logic                busreq_strobe,
    output logic                sc_strobe,
    output logic [SCF_W-1:0]    sc_func,
    output logic                bcc_strobe,
    output logic [BCC_W-1:0]    bcc_sel
);
    logic [OPC_W-1:0] opc;
    logic             active;
    logic             in_t2;
    logic             in_ds;
    logic             ram_write_op;

    assign opc    = ir[OPC_LSB +: OPC_W];
    assign active = (phase != PH_FETCH);
    assign in_t2  = (phase == PH_T2);
    assign in_ds  = (phase == PH_DS);

    // One class flag per opcode value, valid outside FETCH.
    for (genvar g = 0; g < NCLASS; g++) begin : g_class
        assign op_class[g] = active & (opc == OPC_W'(g));
    end

    // The branch decision uses the raw opcode, since it is sampled in T1.
    assign is_branch = (opc == OP_BRA) | (opc == OP_BRB);
    assign tp_sel    = ir[8 +: TP_W];

    // Arithmetic unit control.
    assign alu_strobe = in_t2 & op_class[OP_ALU];
    assign alu_func   = op_class[OP_ALU] ? ir[ALU_W-1:0] : '0;

    // RAM control: bit 8 picks write (DS strobe) or read (T2 strobe).
    assign ram_write_op = op_class[OP_RAM] & ir[8];
    assign ram_wr       = in_ds & ram_write_op;
    assign ram_rd       = in_t2 & op_class[OP_RAM] & ~ir[8];
    assign ram_addr     = op_class[OP_RAM] ? {ir[LOC_W-1:0], line_num} : '0;

    // Transfer-bus source: used by RAM writes and by transfers.
    assign src_en  = ram_write_op | op_class[OP_XFR];
    assign src_sel = src_en ? ir[4 +: SRC_W] : '0;

    // Transfer destination, with the cycle direction for the bus address.
    assign xfer_strobe = in_t2 & op_class[OP_XFR];
    assign xfer_dst    = op_class[OP_XFR] ? ir[DST_W-1:0] : '0;
    assign xfer_bus_wr = xfer_strobe & (ir[DST_W-1:0] == DST_BUSADDR) & ir[9];

    // Bus request pulse.
    assign busreq_strobe = in_t2 & op_class[OP_REQ];

    // Set/clear function strobe.
    assign sc_strobe = in_ds & op_class[OP_SC];
    assign sc_func   = op_class[OP_SC] ? ir[SCF_W-1:0] : '0;

    // Block check: the select comes from the RAM output bits, not from ir.
    assign bcc_strobe = in_ds & op_class[OP_BCC];
    assign bcc_sel    = op_class[OP_BCC] ? ram_bits : '0;
endmodule

// File: rtl/ucode_sequencer.sv
// Top of the microcode sequencer. The phase generator, the fetch unit
// and the decoder are joined here. Assumes an external ROM that answers
// rom_addr combinationally on rom_data.
module ucode_sequencer
    import useq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [AW-1:0]        rom_addr,
    input  logic [IW-1:0]        rom_data,
    input  logic [TP_N-1:0]      test_pts,
    input  logic [LINE_W-1:0]    line_num,
    input  logic [BCC_W-1:0]     ram_bits,
    output logic [PH_W-1:0]      phase_o,
    output logic [NCLASS-1:0]    op_class,
    output logic                 br_taken,
    output logic                 alu_strobe,
    output logic [ALU_W-1:0]     alu_func,
    output logic                 ram_rd,
    output logic                 ram_wr,
    output logic [RAM_AW-1:0]    ram_addr,
    output logic                 src_en,
    output logic [SRC_W-1:0]     src_sel,
    output logic                 xfer_strobe,
    output logic [DST_W-1:0]     xfer_dst,
    output logic                 xfer_bus_wr,
    output logic                 busreq_strobe,
    output logic                 sc_strobe,
    output logic [SCF_W-1:0]     sc_func,
    output logic                 bcc_strobe,
    output logic [BCC_W-1:0]     bcc_sel
);
    phase_t          phase;
    logic [IW-1:0]   ir_q;
    logic            is_branch;
    logic [TP_W-1:0] tp_sel;

    useq_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase)
    );

    useq_fetch u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (phase),
        .rom_data  (rom_data),
        .test_pts  (test_pts),
        .is_branch (is_branch),
        .tp_sel    (tp_sel),
        .rom_addr  (rom_addr),
        .ir        (ir_q),
        .br_taken  (br_taken)
    );

    useq_decode u_decode (
        .phase         (phase),
        .ir            (ir_q),
        .line_num      (line_num),
        .ram_bits      (ram_bits),
        .is_branch     (is_branch),
        .tp_sel        (tp_sel),
        .op_class      (op_class),
        .alu_strobe    (alu_strobe),
        .alu_func      (alu_func),
        .ram_rd        (ram_rd),
        .ram_wr        (ram_wr),
        .ram_addr      (ram_addr),
        .src_en        (src_en),
        .src_sel       (src_sel),
        .xfer_strobe   (xfer_strobe),
        .xfer_dst      (xfer_dst),
        .xfer_bus_wr   (xfer_bus_wr),
        .busreq_strobe (busreq_strobe),
        .sc_strobe     (sc_strobe),
        .sc_func       (sc_func),
        .bcc_strobe    (bcc_strobe),
        .bcc_sel       (bcc_sel)
    );

    assign phase_o = phase;
endmodule

// File: rtl/useq_checker.sv
// Property checker for the microcode sequencer, bound to the top module.
// It watches the ports and the latched microword.
module useq_checker
    import useq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [PH_W-1:0]   phase_o,
    input logic [AW-1:0]     rom_addr,
    input logic [IW-1:0]     ir,
    input logic [NCLASS-1:0] op_class,
    input logic              br_taken,
    input logic              alu_strobe,
    input logic              ram_rd,
    input logic              ram_wr,
    input logic              src_en,
    input logic              xfer_strobe,
    input logic [DST_W-1:0]  xfer_dst,
    input logic              xfer_bus_wr,
    input logic              busreq_strobe,
    input logic              sc_strobe,
    input logic              bcc_strobe
);
    logic [7:0] strobes;
    assign strobes = {br_taken, alu_strobe, ram_rd, ram_wr, xfer_strobe,
                      busreq_strobe, sc_strobe, bcc_strobe};

    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd3) |=> (phase_o == 2'd0)); // R1
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd3) |=> (phase_o == PH_W'($past(phase_o) + 2'd1))); // R1
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_class)); // R2
    AST_TAKEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken |=> (rom_addr == {$past(ir[IW-1]), $past(ir[BR_LO_W-1:0])})); // R3
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == 2'd1 && !br_taken) |=> (rom_addr == AW'($past(rom_addr) + 1'b1))); // R4
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != 2'd1) |=> $stable(rom_addr)); // R4
    AST_RD_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        ram_rd |-> !src_en); // R7
    AST_WR_IN_DS: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr |-> (phase_o == 2'd2)); // R7
    AST_BUSDIR_DST: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_bus_wr |-> (xfer_dst == DST_BUSADDR)); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(strobes)); // R13
endmodule

bind ucode_sequencer useq_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .phase_o       (phase_o),
    .rom_addr      (rom_addr),
    .ir            (ir_q),
    .op_class      (op_class),
    .br_taken      (br_taken),
    .alu_strobe    (alu_strobe),
    .ram_rd        (ram_rd),
    .ram_wr        (ram_wr),
    .src_en        (src_en),
    .xfer_strobe   (xfer_strobe),
    .xfer_dst      (xfer_dst),
    .xfer_bus_wr   (xfer_bus_wr),
    .busreq_strobe (busreq_strobe),
    .sc_strobe     (sc_strobe),
    .bcc_strobe    (bcc_strobe)
);

// File: tb/ucode_sequencer_test.sv
// Directed bench for the microcode sequencer. Each task loads a short
// microprogram, resets, and checks the ports phase by phase.
module ucode_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [1:0] T1 = 2'd0, T2 = 2'd1, DS = 2'd2, FE = 2'd3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  rom_addr;
    logic [15:0] rom_data;
    logic [15:0] test_pts = '0;
    logic [3:0]  line_num = '0;
    logic [1:0]  ram_bits = '0;
    logic [1:0]  phase_o;
    logic [7:0]  op_class;
    logic        br_taken, alu_strobe, ram_rd, ram_wr, src_en;
    logic        xfer_strobe, xfer_bus_wr, busreq_strobe, sc_strobe, bcc_strobe;
    logic [5:0]  alu_func;
    logic [7:0]  ram_addr, sc_func;
    logic [3:0]  src_sel;
    logic [2:0]  xfer_dst;
    logic [1:0]  bcc_sel;

    logic [15:0] rom [0:511];
    int checks = 0;
    int errors = 0;

    assign rom_data = rom[rom_addr];

    always #(CLK_PERIOD/2) clk = ~clk;

    ucode_sequencer uut (
        .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
        .test_pts(test_pts), .line_num(line_num), .ram_bits(ram_bits),
        .phase_o(phase_o), .op_class(op_class), .br_taken(br_taken),
        .alu_strobe(alu_strobe), .alu_func(alu_func), .ram_rd(ram_rd),
        .ram_wr(ram_wr), .ram_addr(ram_addr), .src_en(src_en),
        .src_sel(src_sel), .xfer_strobe(xfer_strobe), .xfer_dst(xfer_dst),
        .xfer_bus_wr(xfer_bus_wr), .busreq_strobe(busreq_strobe),
        .sc_strobe(sc_strobe), .sc_func(sc_func), .bcc_strobe(bcc_strobe),
        .bcc_sel(bcc_sel)
    );

    function automatic logic [15:0] mw(input logic b15, input logic [2:0] op,
                                       input logic [11:0] low);
        return {b15, op, low};
    endfunction

    function automatic logic [7:0] strobes();
        return {br_taken, alu_strobe, ram_rd, ram_wr, xfer_strobe,
                busreq_strobe, sc_strobe, bcc_strobe};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill_rom();
        for (int i = 0; i < 512; i++) rom[i] = mw(1'b0, 3'd1, 12'h000);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step_to(input logic [1:0] p);
        do @(negedge clk); while (phase_o != p);
    endtask

    task automatic t_reset();
        fill_rom();
        do_reset();
        check("R1 reset phase", 32'(phase_o), 32'(FE));
        check("R1 reset addr", 32'(rom_addr), 0);
        check("R1 reset strobes", 32'(strobes()), 0);
        check("R2 class in fetch", 32'(op_class), 0);
        step_to(T1);
        check("R1 phase T1 after fetch", 32'(phase_o), 32'(T1));
    endtask

    task automatic t_alu_seq();
        fill_rom();
        rom[0] = mw(1'b0, 3'd1, 12'h02A);
        rom[1] = mw(1'b0, 3'd1, 12'hF15);
        do_reset();
        step_to(T1);
        check("R2 class ALU", 32'(op_class), 32'h02);
        step_to(T2);
        check("R6 alu strobe", 32'(alu_strobe), 1);
        check("R6 alu func", 32'(alu_func), 32'h2A);
        check("R4 addr held before T2 end", 32'(rom_addr), 0);
        step_to(DS);
        check("R4 addr step", 32'(rom_addr), 1);
        check("R6 strobe only in T2", 32'(alu_strobe), 0);
        step_to(T2);
        check("R5 next word func", 32'(alu_func), 32'h15);
        step_to(DS);
        check("R4 addr step 2", 32'(rom_addr), 2);
    endtask

    task automatic t_branch();
        fill_rom();
        rom[0]     = mw(1'b1, 3'd0, 12'h523);
        rom[9'h123] = mw(1'b0, 3'd5, 12'h05A);
        test_pts = 16'h0020;
        do_reset();
        step_to(T1);
        check("R2 class branch-A", 32'(op_class), 32'h01);
        step_to(T2);
        check("R3 taken flag", 32'(br_taken), 1);
        test_pts = 16'h0000;
        step_to(DS);
        check("R3 target load", 32'(rom_addr), 32'h123);
        step_to(DS);
        check("R5 fetched target word", 32'(sc_strobe), 1);
        check("R11 sc func", 32'(sc_func), 32'h5A);
        // not taken: every condition true except the selected one
        fill_rom();
        rom[0] = mw(1'b1, 3'd0, 12'h5FF);
        test_pts = 16'hFFDF;
        do_reset();
        step_to(T2);
        check("R3 not taken flag", 32'(br_taken), 0);
        step_to(DS);
        check("R4 not taken step", 32'(rom_addr), 1);
        // branch-B form
        fill_rom();
        rom[0] = mw(1'b0, 3'd7, 12'hFAB);
        test_pts = 16'h8000;
        do_reset();
        step_to(T1);
        check("R2 class branch-B", 32'(op_class), 32'h80);
        step_to(DS);
        check("R3 branch-B target", 32'(rom_addr), 32'h0AB);
    endtask

    task automatic t_wrap();
        fill_rom();
        rom[0]      = mw(1'b1, 3'd0, 12'h0FF);
        rom[9'h1FF] = mw(1'b0, 3'd1, 12'h011);
        test_pts = 16'h0001;
        do_reset();
        step_to(DS);
        check("R3 jump to last word", 32'(rom_addr), 32'h1FF);
        step_to(T2);
        check("R5 last word func", 32'(alu_func), 32'h11);
        step_to(DS);
        check("R4 wrap to zero", 32'(rom_addr), 0);
    endtask

    task automatic t_ram();
        fill_rom();
        rom[0] = mw(1'b0, 3'd2, 12'h1C9);
        rom[1] = mw(1'b0, 3'd2, 12'h0F3);
        line_num = 4'h6;
        do_reset();
        step_to(T2);
        check("R7 write: no strobe in T2", 32'({ram_wr, ram_rd}), 0);
        check("R7 write address", 32'(ram_addr), 32'h96);
        step_to(DS);
        check("R7 write strobe", 32'(ram_wr), 1);
        check("R7 write source", 32'({src_en, src_sel}), 32'h1C);
        step_to(T2);
        check("R7 read strobe", 32'(ram_rd), 1);
        check("R7 read address", 32'(ram_addr), 32'h36);
        check("R7 read ignores source bits", 32'({src_en, src_sel}), 0);
        step_to(DS);
        check("R7 read: no write", 32'(ram_wr), 0);
    endtask

    task automatic t_xfer();
        fill_rom();
        rom[0] = mw(1'b0, 3'd3, 12'h275);
        rom[1] = mw(1'b0, 3'd3, 12'h223);
        rom[2] = mw(1'b0, 3'd3, 12'h045);
        do_reset();
        step_to(T2);
        check("R8 xfer strobe", 32'(xfer_strobe), 1);
        check("R8 xfer source", 32'({src_en, src_sel}), 32'h17);
        check("R8 xfer dest", 32'(xfer_dst), 5);
        check("R9 bus write dir", 32'(xfer_bus_wr), 1);
        step_to(T2);
        check("R9 bit9 ignored other dest", 32'(xfer_bus_wr), 0);
        check("R8 xfer dest 3", 32'(xfer_dst), 3);
        step_to(T2);
        check("R9 bus read dir", 32'(xfer_bus_wr), 0);
    endtask

    task automatic t_misc();
        fill_rom();
        rom[0] = mw(1'b0, 3'd4, 12'hFFF);
        rom[1] = mw(1'b0, 3'd6, 12'h018);
        rom[2] = mw(1'b0, 3'd6, 12'h000);
        ram_bits = 2'b01;
        do_reset();
        step_to(T2);
        check("R10 bus request", 32'(busreq_strobe), 1);
        check("R13 single strobe", 32'(strobes()), 32'h04);
        step_to(DS);
        check("R10 request only in T2", 32'(strobes()), 0);
        step_to(DS);
        check("R12 bcc strobe", 32'(bcc_strobe), 1);
        check("R12 bcc select from RAM bits", 32'(bcc_sel), 1);
        check("R13 single strobe bcc", 32'(strobes()), 32'h01);
        ram_bits = 2'b10;
        step_to(DS);
        check("R12 bcc follows RAM bits", 32'(bcc_sel), 2);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
        finish_run();
    end

    initial begin
        t_reset();
        t_alu_seq();
        t_branch();
        t_wrap();
        t_ram();
        t_xfer();
        t_misc();
        finish_run();
    end
endmodule